// File: doc/BRIEF.md
# Configuration Load Sequencing Controller

This block controls one device configuration session. A configuration port issues register writes, each an address and a 32-bit data word. The controller checks that the setup steps arrive in the required order. The identifier written by the host must match the device's own fixed identifier. The watchdog must then be turned off, start-up clocking and timing must be set, and the interconnect must be put into high impedance. Only after all of these does the block accept a frame start address, a write-configuration command and the stream of frame words, which it passes on through a one-cycle frame write enable.

While the session runs, the block keeps a running 32-bit CRC over every register write. A dedicated check register compares this CRC against a value from the host, so corruption in transfer is caught. An identifier mismatch or a CRC mismatch sets a sticky error that blocks frame writes until an error-clear command arrives. A frame data word that arrives before the setup steps are complete is dropped and raises its own sticky error.

After the frame data, a fixed restart sequence runs, one command per step. First a strobe activates the configuration flip-flops. Then the interconnect is released, then start-up is armed, and finally the port is desynchronised, which is the only event that launches the armed start-up. A status word reports the current phase, the control levels and the error flags. All outputs are registered, so each output changes one clock after the write that causes it.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it falls, status is zero and frame_we, ic_hiz, ff_strobe, su_arm, su_run and the three error flags are low. The phase is 0 (waiting for identifier) and the running CRC is zero.
- R2: A write to register 1 (identifier) in phase 0 moves the phase to 1 when the data equals the DEV_ID parameter. When the data differs, err_id is set and the phase stays 0. Identifier writes in any other phase have no effect.
- R3: The setup steps advance only from their own phase. A write to register 2 (watchdog) with data bit 0 clear moves phase 1 to 2. A write to register 3 (start-up setup) moves phase 2 to 3. Command 3 (interconnect Hi-Z) moves phase 3 to 4 and raises ic_hiz. Any step written outside its phase, or a watchdog write with bit 0 set, leaves the phase unchanged.
- R4: A write to register 4 (frame address) in phase 4 or 5 sets the phase to 5 and puts the data on frame_addr. Command 2 (write configuration) moves phase 5 to 6.
- R5: A write to register 5 (frame data) in phase 6, while err_id and err_crc are both low, gives a one-cycle frame_we pulse in the next cycle, with frame_data equal to the written word.
- R6: A frame data write in any phase other than 6 produces no frame_we and sets err_order.
- R7: The CRC is a 32-bit CRC with polynomial 0x04C11DB7, initial value 0, no reflection and no final inversion. It is shifted MSB first over the ADDR_W address bits and then the 32 data bits of every write, except writes to register 6 (CRC check) and command 1 (CRC reset). A write to register 6 compares the data with the current CRC and sets err_crc on a mismatch. Both that write and command 1 clear the CRC to zero.
- R8: The error flags are sticky. While err_id or err_crc is set, frame data writes in phase 6 are dropped without setting err_order. Command 8 (clear errors) clears all three flags.
- R9: The restart advances one step per command, each accepted only from the previous phase. Command 4 moves phase 6 to 7 with a one-cycle ff_strobe pulse. Command 5 moves phase 7 to 8 and drops ic_hiz. Command 6 moves phase 8 to 9 and raises su_arm. Command 7 moves phase 9 to 10 with a one-cycle su_run pulse. Restart commands out of order are ignored.
- R10: Register 0 is the command register, with the command code in data bits 3:0. The status word holds the phase in bits 3:0, ic_hiz in bit 4, su_arm in bit 5, err_id in bit 6, err_crc in bit 7 and err_order in bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Register write data |
| status | output | 9 | Phase, control levels and error flags |
| frame_we | output | 1 | One-cycle frame word valid |
| frame_addr | output | 32 | Loaded frame start address |
| frame_data | output | 32 | Frame word that goes with frame_we |
| ic_hiz | output | 1 | Interconnect held in high impedance |
| ff_strobe | output | 1 | Pulse that activates configuration flip-flops |
| su_arm | output | 1 | Start-up sequence armed |
| su_run | output | 1 | Pulse that launches start-up on desynchronisation |
| err_id | output | 1 | Sticky identifier mismatch |
| err_crc | output | 1 | Sticky CRC mismatch |
| err_order | output | 1 | Sticky out-of-order frame data |

## Verification
The bench first sends a frame word and setup steps before the identifier has been accepted. A controller that does not enforce the order would advance its phase or pulse frame_we instead of raising err_order. It runs random frame words and random ignored writes, then checks the CRC against a value the bench computes itself. A CRC that skipped ignored writes or included the check write would then raise err_crc falsely. A deliberate CRC mismatch must stop frame words without counting as an order error. The restart commands are also given out of order, which exposes a sequencer that would release the interconnect or launch start-up early.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  localparam int PH_W = 4;

  typedef enum logic [PH_W-1:0] {
    PH_WAIT_ID  = 4'd0,
    PH_ID_OK    = 4'd1,
    PH_WDOG_OFF = 4'd2,
    PH_SU_SET   = 4'd3,
    PH_HIZ      = 4'd4,
    PH_ADDR     = 4'd5,
    PH_WRITE    = 4'd6,
    PH_FF_ACT   = 4'd7,
    PH_IC_ON    = 4'd8,
    PH_ARMED    = 4'd9,
    PH_DONE     = 4'd10
  } phase_e;

  localparam int REG_CMD    = 0;
  localparam int REG_IDENT  = 1;
  localparam int REG_WDOG   = 2;
  localparam int REG_SUCFG  = 3;
  localparam int REG_FADDR  = 4;
  localparam int REG_FDATA  = 5;
  localparam int REG_CRCCHK = 6;

  localparam logic [3:0] CMD_RCRC   = 4'd1;
  localparam logic [3:0] CMD_WCFG   = 4'd2;
  localparam logic [3:0] CMD_HIZ    = 4'd3;
  localparam logic [3:0] CMD_ACTFF  = 4'd4;
  localparam logic [3:0] CMD_ICON   = 4'd5;
  localparam logic [3:0] CMD_ARM    = 4'd6;
  localparam logic [3:0] CMD_DESYNC = 4'd7;
  localparam logic [3:0] CMD_RERR   = 4'd8;

  typedef struct packed {
    logic       cmd;
    logic [3:0] code;
    logic       ident;
    logic       wdog;
    logic       sucfg;
    logic       faddr;
    logic       fdata;
    logic       crcchk;
  } wr_dec_t;
endpackage

// File: rtl/cfg_crc_acc.sv
module cfg_crc_acc #(
  parameter int          ADDR_W = 4,
  parameter int          DATA_W = 32,
  parameter int          CRC_W  = 32,
  parameter logic [31:0] POLY   = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              is_chk,
  input  logic              is_clr,
  output logic              crc_bad
);
  localparam int MSG_W = ADDR_W + DATA_W;

  logic [CRC_W-1:0] crc_q, crc_nx;
  logic [MSG_W-1:0] msg;

  assign msg = {wr_addr, wr_data};

  always_comb begin
    crc_nx = crc_q;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      if (crc_nx[CRC_W-1] ^ msg[i])
        crc_nx = {crc_nx[CRC_W-2:0], 1'b0} ^ POLY[CRC_W-1:0];
      else
        crc_nx = {crc_nx[CRC_W-2:0], 1'b0};
    end
  end

  assign crc_bad = wr_en && is_chk && (wr_data[CRC_W-1:0] != crc_q);

  always_ff @(posedge clk) begin
    if (rst) crc_q <= '0;
    else if (wr_en) begin
      if (is_chk || is_clr) crc_q <= '0;
      else                  crc_q <= crc_nx;
    end
  end
endmodule

// File: rtl/cfg_err_flags.sv
module cfg_err_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_id,
  input  logic set_crc,
  input  logic set_order,
  input  logic clr,
  output logic err_id,
  output logic err_crc,
  output logic err_order
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      err_id    <= 1'b0;
      err_crc   <= 1'b0;
      err_order <= 1'b0;
    end else begin
      err_id    <= err_id    | set_id;
      err_crc   <= err_crc   | set_crc;
      err_order <= err_order | set_order;
    end
  end
endmodule

// File: rtl/cfg_phase_fsm.sv
module cfg_phase_fsm
  import cfg_seq_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [31:0] DEV_ID = 32'h3A5C_0093
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  wr_dec_t           dec,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              blocked,
  output phase_e            phase,
  output logic              frame_we,
  output logic [DATA_W-1:0] frame_addr,
  output logic [DATA_W-1:0] frame_data,
  output logic              ic_hiz,
  output logic              ff_strobe,
  output logic              su_arm,
  output logic              su_run,
  output logic              id_bad,
  output logic              order_bad
);
  logic c_hiz, c_wcfg, c_actff, c_icon, c_arm, c_desync;

  assign c_hiz    = wr_en && dec.cmd && dec.code == CMD_HIZ;
  assign c_wcfg   = wr_en && dec.cmd && dec.code == CMD_WCFG;
  assign c_actff  = wr_en && dec.cmd && dec.code == CMD_ACTFF;
  assign c_icon   = wr_en && dec.cmd && dec.code == CMD_ICON;
  assign c_arm    = wr_en && dec.cmd && dec.code == CMD_ARM;
  assign c_desync = wr_en && dec.cmd && dec.code == CMD_DESYNC;

  assign id_bad    = wr_en && dec.ident && phase == PH_WAIT_ID
                     && wr_data != DEV_ID[DATA_W-1:0];
  assign order_bad = wr_en && dec.fdata && phase != PH_WRITE;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_WAIT_ID;
      frame_we   <= 1'b0;
      frame_addr <= '0;
      frame_data <= '0;
      ic_hiz     <= 1'b0;
      ff_strobe  <= 1'b0;
      su_arm     <= 1'b0;
      su_run     <= 1'b0;
    end else begin
      frame_we  <= 1'b0;
      ff_strobe <= 1'b0;
      su_run    <= 1'b0;
      unique case (phase)
        PH_WAIT_ID:
          if (wr_en && dec.ident && wr_data == DEV_ID[DATA_W-1:0])
            phase <= PH_ID_OK;
        PH_ID_OK:
          if (wr_en && dec.wdog && !wr_data[0]) phase <= PH_WDOG_OFF;
        PH_WDOG_OFF:
          if (wr_en && dec.sucfg) phase <= PH_SU_SET;
        PH_SU_SET:
          if (c_hiz) begin
            phase  <= PH_HIZ;
            ic_hiz <= 1'b1;
          end
        PH_HIZ, PH_ADDR:
          if (wr_en && dec.faddr) begin
            phase      <= PH_ADDR;
            frame_addr <= wr_data;
          end else if (c_wcfg && phase == PH_ADDR) begin
            phase <= PH_WRITE;
          end
        PH_WRITE:
          if (wr_en && dec.fdata && !blocked) begin
            frame_we   <= 1'b1;
            frame_data <= wr_data;
          end else if (c_actff) begin
            phase     <= PH_FF_ACT;
            ff_strobe <= 1'b1;
          end
        PH_FF_ACT:
          if (c_icon) begin
            phase  <= PH_IC_ON;
            ic_hiz <= 1'b0;
          end
        PH_IC_ON:
          if (c_arm) begin
            phase  <= PH_ARMED;
            su_arm <= 1'b1;
          end
        PH_ARMED:
          if (c_desync) begin
            phase  <= PH_DONE;
            su_run <= 1'b1;
          end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int          ADDR_W = 4,
  parameter logic [31:0] DEV_ID = 32'h3A5C_0093
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [8:0]        status,
  output logic              frame_we,
  output logic [31:0]       frame_addr,
  output logic [31:0]       frame_data,
  output logic              ic_hiz,
  output logic              ff_strobe,
  output logic              su_arm,
  output logic              su_run,
  output logic              err_id,
  output logic              err_crc,
  output logic              err_order
);
  localparam int DATA_W = 32;

  wr_dec_t dec;
  phase_e  phase;
  logic    crc_bad, id_bad, order_bad;

  always_comb begin
    dec.cmd    = wr_addr == ADDR_W'(REG_CMD);
    dec.code   = wr_data[3:0];
    dec.ident  = wr_addr == ADDR_W'(REG_IDENT);
    dec.wdog   = wr_addr == ADDR_W'(REG_WDOG);
    dec.sucfg  = wr_addr == ADDR_W'(REG_SUCFG);
    dec.faddr  = wr_addr == ADDR_W'(REG_FADDR);
    dec.fdata  = wr_addr == ADDR_W'(REG_FDATA);
    dec.crcchk = wr_addr == ADDR_W'(REG_CRCCHK);
  end

  cfg_crc_acc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_crc (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .is_chk  (dec.crcchk),
    .is_clr  (dec.cmd && dec.code == CMD_RCRC),
    .crc_bad (crc_bad)
  );

  cfg_err_flags u_err (
    .clk       (clk),
    .rst       (rst),
    .set_id    (id_bad),
    .set_crc   (crc_bad),
    .set_order (order_bad),
    .clr       (wr_en && dec.cmd && dec.code == CMD_RERR),
    .err_id    (err_id),
    .err_crc   (err_crc),
    .err_order (err_order)
  );

  cfg_phase_fsm #(.DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .dec        (dec),
    .wr_data    (wr_data),
    .blocked    (err_id || err_crc),
    .phase      (phase),
    .frame_we   (frame_we),
    .frame_addr (frame_addr),
    .frame_data (frame_data),
    .ic_hiz     (ic_hiz),
    .ff_strobe  (ff_strobe),
    .su_arm     (su_arm),
    .su_run     (su_run),
    .id_bad     (id_bad),
    .order_bad  (order_bad)
  );

  assign status = {err_order, err_crc, err_id, su_arm, ic_hiz, phase};
endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk
  import cfg_seq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [8:0]        status,
  input logic              frame_we,
  input logic              ic_hiz,
  input logic              ff_strobe,
  input logic              su_arm,
  input logic              su_run,
  input logic              err_id,
  input logic              err_crc,
  input logic              err_order
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      p_reset_clear_r1: assert (status == '0 && !frame_we && !ff_strobe && !su_run)
        else $error("status not clear after reset");
    end
  end

  p_frame_gate_r5: assert property (@(posedge clk) disable iff (rst)
    frame_we |-> (status[3:0] == PH_WRITE) && !$past(err_id || err_crc));

  p_order_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(REG_FDATA) && status[3:0] != PH_WRITE) |=> err_order && !frame_we);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (err_order && !(wr_en && wr_addr == ADDR_W'(REG_CMD) && wr_data[3:0] == CMD_RERR)) |=> err_order);

  p_strobe_hiz_r9: assert property (@(posedge clk) disable iff (rst)
    ff_strobe |-> ic_hiz && status[3:0] == PH_FF_ACT);

  p_run_after_arm_r9: assert property (@(posedge clk) disable iff (rst)
    su_run |-> su_arm && !ic_hiz && status[3:0] == PH_DONE);

  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_we, ff_strobe, su_run}));
endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cfg_seq_ctrl_tb.sv
module cfg_seq_ctrl_tb;
  localparam int          AW  = 4;
  localparam logic [31:0] DID = 32'h3A5C_0093;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [8:0]    status;
  logic          frame_we, ic_hiz, ff_strobe, su_arm, su_run;
  logic          err_id, err_crc, err_order;
  logic [31:0]   frame_addr, frame_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] crc_m = '0;
  int unsigned seed_v;

  always #2.5 clk = ~clk;

  cfg_seq_ctrl #(.ADDR_W(AW), .DEV_ID(DID)) u_dut (.*);

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [AW-1:0] a, logic [31:0] d);
    logic [AW+31:0] m;
    m = {a, d};
    for (int i = AW + 31; i >= 0; i--) begin
      if (c[31] ^ m[i]) c = {c[30:0], 1'b0} ^ 32'h04C1_1DB7;
      else              c = {c[30:0], 1'b0};
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 6 || (a == 0 && d[3:0] == 4'd1)) crc_m = '0;
    else crc_m = crc_step(crc_m, AW'(a), d);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    seed_v = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(status == 9'd0 && !frame_we && !ff_strobe && !su_run && !ic_hiz,
          "R1 reset state", 32'(status), 32'd0);

    wr(5, 32'h1111_2222);
    check(err_order && !frame_we && status[3:0] == 4'd0, "R6 early frame word", 32'(status), 32'h100);
    wr(0, 32'd8);
    check(!err_order, "R8 clear errors", 32'(err_order), 0);

    wr(1, DID ^ 32'h1);
    check(err_id && status[3:0] == 4'd0, "R2 identifier mismatch", 32'(status), 32'h40);
    wr(2, 32'd0);
    check(status[3:0] == 4'd0, "R3 watchdog before identifier ignored", 32'(status[3:0]), 0);
    wr(0, 32'd8);
    check(!err_id, "R8 clear id error", 32'(err_id), 0);

    wr(1, DID);
    check(status[3:0] == 4'd1 && !err_id, "R2 identifier match", 32'(status[3:0]), 1);
    wr(3, 32'h5);
    check(status[3:0] == 4'd1, "R3 start-up setup out of order", 32'(status[3:0]), 1);
    wr(2, 32'd1);
    check(status[3:0] == 4'd1, "R3 watchdog still enabled", 32'(status[3:0]), 1);
    wr(2, 32'd0);
    check(status[3:0] == 4'd2, "R3 watchdog off", 32'(status[3:0]), 2);
    wr(3, 32'h77);
    check(status[3:0] == 4'd3, "R3 start-up set", 32'(status[3:0]), 3);
    wr(0, 32'd3);
    check(status[3:0] == 4'd4 && ic_hiz && status[4], "R3 R10 interconnect hi-z", 32'(status), 32'h14);

    wr(0, 32'd2);
    check(status[3:0] == 4'd4, "R4 write command before address", 32'(status[3:0]), 4);
    wr(4, 32'h0042_0100);
    check(status[3:0] == 4'd5 && frame_addr == 32'h0042_0100, "R4 frame address", frame_addr, 32'h0042_0100);
    wr(0, 32'd2);
    check(status[3:0] == 4'd6, "R4 write configuration", 32'(status[3:0]), 6);

    for (int k = 0; k < 40; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (w[0]) begin
        wr(3, w);
        check(status[3:0] == 4'd6 && !frame_we, "R3 stray setup ignored", 32'(status[3:0]), 6);
      end else begin
        wr(5, w);
        check(frame_we && frame_data == w, "R5 frame word", frame_data, w);
        idle();
        check(!frame_we, "R5 single pulse", 32'(frame_we), 0);
      end
    end

    wr(6, crc_m);
    check(!err_crc, "R7 CRC match", 32'(err_crc), 0);
    wr(5, 32'hDEAD_0001);
    wr(6, 32'h0BAD_0BAD);
    check(err_crc, "R7 CRC mismatch", 32'(err_crc), 1);
    wr(5, 32'hCAFE_0002);
    check(!frame_we && !err_order, "R8 blocked frame word", 32'(frame_we), 0);
    wr(0, 32'd8);
    wr(5, 32'hCAFE_0003);
    check(frame_we && frame_data == 32'hCAFE_0003 && !err_crc, "R8 frames after clear", frame_data, 32'hCAFE_0003);
    wr(0, 32'd1);
    wr(6, 32'd0);
    check(!err_crc, "R7 CRC reset command", 32'(err_crc), 0);
    wr(3, 32'h1234);
    wr(6, crc_m);
    check(!err_crc, "R7 CRC over ignored write", 32'(err_crc), 0);

    wr(0, 32'd6);
    check(status[3:0] == 4'd6 && !su_arm, "R9 arm out of order", 32'(status[3:0]), 6);
    wr(0, 32'd4);
    check(ff_strobe && status[3:0] == 4'd7 && ic_hiz, "R9 flip-flop strobe", 32'(status), 32'h17);
    idle();
    check(!ff_strobe, "R9 strobe single", 32'(ff_strobe), 0);
    wr(0, 32'd7);
    check(status[3:0] == 4'd7 && !su_run, "R9 desync out of order", 32'(status[3:0]), 7);
    wr(0, 32'd5);
    check(status[3:0] == 4'd8 && !ic_hiz, "R9 interconnect released", 32'(status), 32'h08);
    wr(0, 32'd6);
    check(status == 9'h029 && su_arm, "R9 R10 armed", 32'(status), 32'h029);
    wr(0, 32'd7);
    check(su_run && status[3:0] == 4'd10, "R9 start-up run", 32'(status), 32'h02A);
    idle();
    check(!su_run, "R9 run single pulse", 32'(su_run), 0);
    wr(5, 32'h1);
    check(err_order && status[8] && !frame_we, "R6 R10 frame word after restart", 32'(status), 32'h12A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule